// File: doc/BRIEF.md
# In-Order Retirement Reorder Buffer

This block is a circular buffer that holds in-flight instructions between dispatch and retirement. Instructions enter one per cycle, in program order, at the tail. Each one receives a slot index that the execution side later uses to report its result. Results may come back in any order. Branch entries also wait for a separate resolution report that says whether the prediction was correct.

The head slot leaves the buffer only once its work is finished. For an ordinary entry this means a result has arrived. For a branch it means the resolution has arrived. When the head leaves, its destination register and value are presented on the retire port so that the architected register state can be updated. At most one entry leaves per cycle.

If the branch at the head was mispredicted, it still retires, and a flush pulse is raised in the same cycle. Every younger entry is then dropped, and the tail is pulled back to the slot just after the retiring branch. Because retirement is strictly from the head, every entry that reaches the head is already known to lie on the correct path.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_idx` is 0, and `ret_valid` and `flush_o` are 0.
- R2: Each accepted dispatch is given the index shown on `disp_idx`. Successive accepted dispatches receive consecutive indices modulo DEPTH, so index 7 is followed by 0 at the default depth.
- R3: When DEPTH entries are held and none is retiring, `disp_ready` is 0. A dispatch attempted then is dropped and `disp_idx` does not move.
- R4: A non-branch entry retires once it is at the head and its result has arrived. Retirement raises `ret_valid` for one cycle, with the dispatched destination on `ret_dest` and the completed value on `ret_value`. At most one entry retires per cycle.
- R5: A result may arrive for a younger entry before an older one. The younger entry does not retire until every older entry has retired, so entries always retire in dispatch order.
- R6: A branch entry (`disp_is_branch`=1) does not retire before its resolution arrives, even if a result was written to it. After a resolution with `res_mispredict`=0, it retires with `flush_o`=0.
- R7: A branch resolved with `res_mispredict`=1 retires from the head with `flush_o`=1 in that cycle. No younger entry ever retires, and the next dispatch index becomes the slot after the branch.
- R8: During a flush cycle `disp_ready` is 0, and a dispatch offered in that cycle is not accepted.
- R9: When the buffer is full and the head is retiring in the same cycle, `disp_ready` is 1 and a dispatch in that cycle is accepted.
- R10: A completion aimed at a slot that holds no entry is ignored. An entry dispatched into that slot later still waits for its own completion.
- R11: A resolution aimed at a non-branch entry is ignored. That entry retires with `flush_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_dest | input | REG_W | Destination architected register of the new entry |
| disp_is_branch | input | 1 | New entry is a branch and waits for resolution |
| disp_ready | output | 1 | Dispatch will be accepted this cycle |
| disp_idx | output | IDX_W | Slot index given to the entry dispatched this cycle |
| cmp_valid | input | 1 | Result report this cycle |
| cmp_idx | input | IDX_W | Slot that the result belongs to |
| cmp_value | input | DATA_W | Result value |
| res_valid | input | 1 | Branch resolution report this cycle |
| res_idx | input | IDX_W | Slot of the resolved branch |
| res_mispredict | input | 1 | 1: prediction was wrong, 0: prediction was right |
| ret_valid | output | 1 | Head entry retires this cycle |
| ret_dest | output | REG_W | Destination register of the retiring entry |
| ret_value | output | DATA_W | Value of the retiring entry |
| flush_o | output | 1 | Retiring entry is a mispredicted branch; younger entries are dropped |

## Verification
The bound checker keeps its own occupancy count and checks several rules on every cycle. These are: nothing retires from an empty buffer, dispatch is refused only when full and not retiring, the slot index steps by one per accepted dispatch, and a flush always comes with a retirement, blocks dispatch and leaves nothing to retire in the next cycle. What the checker cannot see is whether the right data leaves in the right order. The bench scenarios cover that part: out-of-order completions, branches held back until resolution, stray completions and resolutions, discarded younger entries, and the full-while-retiring case, each compared against a scoreboard of expected retirements.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Branch tracking state held in every slot
    typedef enum logic [1:0] {
        BR_NONE = 2'd0,   // not a branch
        BR_WAIT = 2'd1,   // branch, outcome unknown
        BR_GOOD = 2'd2,   // branch, predicted correctly
        BR_BAD  = 2'd3    // branch, mispredicted
    } rob_br_e;

endpackage

// File: rtl/rob_wrap_inc.sv
module rob_wrap_inc #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] nxt
);
    localparam bit POW2 = (DEPTH == (1 << IDX_W));

    generate
        if (POW2) begin : g_pow2
            // natural wrap of the counter width
            assign nxt = idx + IDX_W'(1);
        end else begin : g_cmp
            assign nxt = (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + IDX_W'(1);
        end
    endgenerate
endmodule

// File: rtl/rob_head_eval.sv
module rob_head_eval
    import rob_pkg::*;
(
    input  logic    valid,
    input  logic    done,
    input  rob_br_e br,
    output logic    fire,
    output logic    mispredict
);
    logic ready;

    always_comb begin
        // branches finish on resolution, others on result arrival
        if (br == BR_NONE) ready = done;
        else               ready = (br == BR_GOOD) || (br == BR_BAD);
        fire       = valid && ready;
        mispredict = fire && (br == BR_BAD);
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [REG_W-1:0]  disp_dest,
    input  logic              disp_is_branch,
    output logic              disp_ready,
    output logic [IDX_W-1:0]  disp_idx,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic [DATA_W-1:0] cmp_value,
    input  logic              res_valid,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic              res_mispredict,
    output logic              ret_valid,
    output logic [REG_W-1:0]  ret_dest,
    output logic [DATA_W-1:0] ret_value,
    output logic              flush_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              valid;
        logic              done;
        rob_br_e           br;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] value;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic [IDX_W-1:0]  head;
        logic [IDX_W-1:0]  tail;
        logic [CNT_W-1:0]  count;
    } state_t;

    state_t s_q, s_d;

    logic             fire, mispredict, accept;
    logic             cmp_hit, res_hit;
    logic [IDX_W-1:0] head_nxt, tail_nxt;

    rob_head_eval u_head (
        .valid      (s_q.slot[s_q.head].valid),
        .done       (s_q.slot[s_q.head].done),
        .br         (s_q.slot[s_q.head].br),
        .fire       (fire),
        .mispredict (mispredict)
    );

    rob_wrap_inc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_head_inc (
        .idx (s_q.head),
        .nxt (head_nxt)
    );

    rob_wrap_inc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tail_inc (
        .idx (s_q.tail),
        .nxt (tail_nxt)
    );

    always_comb begin
        // reports to empty or out-of-range slots are dropped (R10, R11)
        cmp_hit = cmp_valid && (int'(cmp_idx) < DEPTH) && s_q.slot[cmp_idx].valid;
        res_hit = res_valid && (int'(res_idx) < DEPTH) && s_q.slot[res_idx].valid
                  && (s_q.slot[res_idx].br == BR_WAIT);
        // full is fine if the head leaves this cycle; never during flush
        disp_ready = ((s_q.count != CNT_W'(DEPTH)) || fire) && !mispredict;
        accept     = disp_valid && disp_ready;

        s_d = s_q;

        if (cmp_hit) begin
            s_d.slot[cmp_idx].value = cmp_value;
            s_d.slot[cmp_idx].done  = 1'b1;
        end

        if (res_hit) begin
            s_d.slot[res_idx].br = res_mispredict ? BR_BAD : BR_GOOD;
        end

        if (fire) begin
            s_d.slot[s_q.head].valid = 1'b0;
            s_d.head                 = head_nxt;
        end

        if (mispredict) begin
            // drop everything younger than the retiring branch
            for (int i = 0; i < DEPTH; i++) begin
                s_d.slot[i].valid = 1'b0;
            end
            s_d.tail  = head_nxt;
            s_d.count = '0;
        end else begin
            if (accept) begin
                s_d.slot[s_q.tail].valid = 1'b1;
                s_d.slot[s_q.tail].done  = 1'b0;
                s_d.slot[s_q.tail].br    = disp_is_branch ? BR_WAIT : BR_NONE;
                s_d.slot[s_q.tail].dest  = disp_dest;
                s_d.slot[s_q.tail].value = '0;
                s_d.tail                 = tail_nxt;
            end
            s_d.count = s_q.count + CNT_W'(accept) - CNT_W'(fire);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign disp_idx  = s_q.tail;
    assign ret_valid = fire;
    assign ret_dest  = s_q.slot[s_q.head].dest;
    assign ret_value = s_q.slot[s_q.head].value;
    assign flush_o   = mispredict;

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [IDX_W-1:0] disp_idx,
    input logic             ret_valid,
    input logic             flush_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] occ;

    function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
        return (int'(i) == DEPTH - 1) ? '0 : i + IDX_W'(1);
    endfunction

    // independent occupancy model built from port traffic
    always_ff @(posedge clk) begin
        if (!rst_n)       occ <= '0;
        else if (flush_o) occ <= '0;
        else              occ <= occ + CNT_W'(disp_valid && disp_ready) - CNT_W'(ret_valid);
    end

    // R1
    empty_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !ret_valid);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    // R3
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(occ) == DEPTH) && !ret_valid) |-> !disp_ready);

    // R3
    room_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(occ) < DEPTH) && !flush_o) |-> disp_ready);

    // R9
    full_retire_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !flush_o) |-> disp_ready);

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> (disp_idx == step_idx($past(disp_idx))));

    // R7
    flush_with_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> ret_valid);

    // R7
    post_flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !ret_valid);

    // R8
    flush_blocks_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> !disp_ready);

endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_idx   (disp_idx),
    .ret_valid  (ret_valid),
    .flush_o    (flush_o)
);

// File: tb/rob_core_tb.sv
`timescale 1ns/1ps
module rob_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [4:0]  disp_dest = '0;
    logic        disp_is_branch = 1'b0;
    logic        disp_ready;
    logic [2:0]  disp_idx;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_idx = '0;
    logic [31:0] cmp_value = '0;
    logic        res_valid = 1'b0;
    logic [2:0]  res_idx = '0;
    logic        res_mispredict = 1'b0;
    logic        ret_valid;
    logic [4:0]  ret_dest;
    logic [31:0] ret_value;
    logic        flush_o;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [4:0]  d;
        logic [31:0] v;
        bit          f;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    rob_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_is_branch(disp_is_branch),
        .disp_ready(disp_ready), .disp_idx(disp_idx),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_value(cmp_value),
        .res_valid(res_valid), .res_idx(res_idx), .res_mispredict(res_mispredict),
        .ret_valid(ret_valid), .ret_dest(ret_dest), .ret_value(ret_value), .flush_o(flush_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [4:0] d, input logic [31:0] v, input bit f, input string tag);
        exp_t e;
        e.d = d; e.v = v; e.f = f; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic disp(input logic [4:0] d, input bit br, input int exp_idx, input string tag);
        chk(disp_ready == 1'b1, tag, disp_ready, 1);
        chk(int'(disp_idx) == exp_idx, tag, disp_idx, exp_idx);
        disp_valid = 1'b1; disp_dest = d; disp_is_branch = br;
        step();
        disp_valid = 1'b0; disp_is_branch = 1'b0;
    endtask

    task automatic cmp(input int idx, input logic [31:0] v);
        cmp_valid = 1'b1; cmp_idx = 3'(idx); cmp_value = v;
        step();
        cmp_valid = 1'b0;
    endtask

    task automatic res(input int idx, input bit mp);
        res_valid = 1'b1; res_idx = 3'(idx); res_mispredict = mp;
        step();
        res_valid = 1'b0; res_mispredict = 1'b0;
    endtask

    // monitor: every retirement is popped from the scoreboard
    always @(negedge clk) begin
        if (rst_n && ret_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected retire", ret_dest, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(ret_dest == e.d, {e.tag, " dest"}, ret_dest, e.d);
                chk(ret_value == e.v, {e.tag, " value"}, ret_value, e.v);
                chk(flush_o == e.f, {e.tag, " flush"}, flush_o, e.f);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(disp_ready == 1'b1, "R1 ready", disp_ready, 1);
        chk(disp_idx == 3'd0, "R1 idx", disp_idx, 0);
        chk(ret_valid == 1'b0, "R1 ret_valid", ret_valid, 0);
        chk(flush_o == 1'b0, "R1 flush", flush_o, 0);

        // R2 R4 R5: out-of-order completion, in-order retirement
        push(5'd1, 32'd11, 1'b0, "R5");
        disp(5'd1, 1'b0, 0, "R2");
        push(5'd2, 32'd22, 1'b0, "R5");
        disp(5'd2, 1'b0, 1, "R2");
        push(5'd3, 32'd33, 1'b0, "R5");
        disp(5'd3, 1'b0, 2, "R2");
        cmp(2, 32'd33);
        cmp(1, 32'd22);
        chk(ret_valid == 1'b0, "R5 younger held", ret_valid, 0);
        cmp(0, 32'd11);
        step(); step(); step();
        chk(sb.size() == 0, "R4 all retired", sb.size(), 0);

        // R6 R11: branch waits for resolution; stray resolution ignored
        push(5'd5, 32'd55, 1'b0, "R6");
        disp(5'd5, 1'b1, 3, "R2");
        push(5'd6, 32'd66, 1'b0, "R11");
        disp(5'd6, 1'b0, 4, "R2");
        cmp(3, 32'd55);
        cmp(4, 32'd66);
        res(4, 1'b1);
        step();
        chk(ret_valid == 1'b0, "R6 branch held", ret_valid, 0);
        res(3, 1'b0);
        step(); step();
        chk(sb.size() == 0, "R6 drained", sb.size(), 0);

        // R10: completion to an empty slot is dropped
        cmp(5, 32'd999);
        push(5'd7, 32'd77, 1'b0, "R10");
        disp(5'd7, 1'b0, 5, "R2");
        step(); step();
        chk(ret_valid == 1'b0, "R10 still waiting", ret_valid, 0);
        cmp(5, 32'd77);
        step();
        chk(sb.size() == 0, "R10 drained", sb.size(), 0);

        // R7 R8: mispredicted branch flushes younger entries
        push(5'd8, 32'd88, 1'b1, "R7");
        disp(5'd8, 1'b1, 6, "R2");
        disp(5'd9, 1'b0, 7, "R2");
        disp(5'd10, 1'b0, 0, "R2");
        disp(5'd11, 1'b0, 1, "R2");
        cmp(7, 32'd901);
        cmp(0, 32'd902);
        cmp(1, 32'd903);
        cmp(6, 32'd88);
        chk(ret_valid == 1'b0, "R6 unresolved", ret_valid, 0);
        res(6, 1'b1);
        chk(flush_o == 1'b1, "R7 flush pulse", flush_o, 1);
        chk(disp_ready == 1'b0, "R8 ready low", disp_ready, 0);
        disp_valid = 1'b1; disp_dest = 5'd12;
        step();
        disp_valid = 1'b0;
        chk(disp_idx == 3'd7, "R8 idx after flush", disp_idx, 7);
        chk(flush_o == 1'b0, "R7 single pulse", flush_o, 1'b0);
        step(); step();
        chk(ret_valid == 1'b0, "R7 younger gone", ret_valid, 0);
        chk(sb.size() == 0, "R7 drained", sb.size(), 0);

        // R3 R9: fill, refuse, then accept while retiring
        for (int k = 0; k < 8; k++) begin
            push(5'(16 + k), 32'(200 + k), 1'b0, "R9");
            disp(5'(16 + k), 1'b0, (7 + k) % 8, "R2");
        end
        chk(disp_ready == 1'b0, "R3 full", disp_ready, 0);
        disp_valid = 1'b1; disp_dest = 5'd30;
        step();
        disp_valid = 1'b0;
        chk(disp_idx == 3'd7, "R3 idx held", disp_idx, 7);
        cmp(7, 32'd200);
        chk(ret_valid == 1'b1, "R9 retiring", ret_valid, 1);
        chk(disp_ready == 1'b1, "R9 ready when full", disp_ready, 1);
        push(5'd31, 32'd300, 1'b0, "R9");
        disp_valid = 1'b1; disp_dest = 5'd31;
        step();
        disp_valid = 1'b0;
        chk(disp_idx == 3'd0, "R9 idx advanced", disp_idx, 0);
        chk(disp_ready == 1'b0, "R3 full again", disp_ready, 0);
        for (int j = 0; j < 7; j++) begin
            cmp(j, 32'(201 + j));
        end
        cmp(7, 32'd300);
        step(); step(); step();
        chk(sb.size() == 0, "R4 drained", sb.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule